// File: doc/BRIEF.md
# Prioritized Interrupt Entry Sequencer

This block is the interrupt-entry engine of a 16-bit processor whose general registers live in memory, addressed through a workspace pointer. It watches an active-high request line together with a 4-bit priority code, where code 1 is the most urgent and code 0 is reserved for reset and never taken. It compares the code against the mask held in the low four bits of the status word. When the processor reports an instruction boundary and the request qualifies, the block takes over a word-wide memory port. It fetches a fresh workspace pointer and program counter from a vector table, then stores the interrupted context into registers 13, 14 and 15 of the new workspace.

The mask is lowered to the accepted code minus one, so the same source cannot re-enter at once. That update is held back by a pending flag until the old status word has been written out, which means a later return restores the pre-interrupt level. An idle mode parks the processor until a qualifying request appears, with no instruction boundary needed. The owning core loads the workspace pointer, program counter and status through a simple load strobe whenever no switch is in progress.

Top module: `irq_ctx_seq`

## Requirements
- R1: While rst_n is low and on the first cycle after it, wp_o, pc_o and st_o read 0, and busy, done, irq_ack, idle_o, mem_req and mem_we are all low.
- R2: In the run state, an interrupt is accepted on a clock edge where at_boundary is high, irq_req is high, irq_code is nonzero and irq_code <= st_o[3:0] (unsigned). busy is high from the next cycle.
- R3: A request with irq_code equal to 0, with irq_code above st_o[3:0], with irq_req low, or with at_boundary low in the run state is ignored: busy stays low, no memory access occurs and wp_o, pc_o and st_o keep their values.
- R4: The first access reads address irq_code*4 and gives the new workspace pointer, with bit 0 forced to 0. The second reads irq_code*4+2 and gives the new program counter. irq_ack is high during the first read and low at every other time.
- R5: Three writes then follow, in this order: the old wp_o to newWP+26, the old pc_o to newWP+28, and the old st_o to newWP+30.
- R6: st_o does not change while busy is high, so the saved status still carries the old mask. On completion st_o[3:0] becomes irq_code-1 and st_o[15:4] is kept.
- R7: busy stays high through the whole sequence. done is a single-cycle pulse in the first cycle after busy falls, and in that cycle wp_o and pc_o already hold the new values.
- R8: Each access keeps mem_req, mem_we, mem_addr and mem_wdata steady until a cycle with mem_ready high, and the sequencer advances only on that cycle.
- R9: idle_cmd in the run state, with no interrupt being accepted, enters idle mode and raises idle_o. Idle mode ignores non-qualifying requests, and a request meeting the R2 code and mask rule starts the sequence without at_boundary.
- R10: ld_en loads ld_wp, ld_pc and ld_st on the next edge in the run state when no interrupt is accepted on that edge. ld_en has no effect while busy is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_req | input | 1 | Interrupt request, active high |
| irq_code | input | 4 | Priority code of the request, 1 most urgent |
| at_boundary | input | 1 | Core is between instructions |
| idle_cmd | input | 1 | Enter idle wait |
| ld_en | input | 1 | Load context registers from the core |
| ld_wp | input | 16 | Workspace pointer to load |
| ld_pc | input | 16 | Program counter to load |
| ld_st | input | 16 | Status word to load |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 16 | Byte address, word aligned |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid with mem_ready |
| mem_ready | input | 1 | Access completes this cycle |
| irq_ack | output | 1 | Vector workspace-pointer fetch in progress |
| busy | output | 1 | Context switch in progress |
| done | output | 1 | One-cycle pulse, new context loaded |
| idle_o | output | 1 | Idle wait active |
| wp_o | output | 16 | Current workspace pointer |
| pc_o | output | 16 | Current program counter |
| st_o | output | 16 | Current status word, mask in bits 3:0 |

## Verification
The assertions assume that irq_code and irq_req are steady on the edge where a request is taken. They also assume that mem_ready rises only while mem_req is high, and that mem_rdata is valid on that cycle. The bench drives every input on the falling edge and keeps code and request fixed from before the boundary strobe until done. Its memory model raises mem_ready only for an outstanding request, after a set number of wait cycles, and lowers it again on the next cycle. The vector table is placed below every workspace, so saves never overwrite vector entries.

// File: rtl/irq_ctx_pkg.sv
// Shared types for the interrupt entry sequencer.
// Assumes a single clock domain; no state is encoded outside this enum.
package irq_ctx_pkg;

    typedef enum logic [2:0] {
        SQ_RUN  = 3'd0,  // executing, watching boundaries
        SQ_IDLE = 3'd1,  // parked until a qualifying request
        SQ_VWP  = 3'd2,  // read vector workspace pointer
        SQ_VPC  = 3'd3,  // read vector program counter
        SQ_SWP  = 3'd4,  // save old workspace pointer
        SQ_SPC  = 3'd5,  // save old program counter
        SQ_SST  = 3'd6   // save old status
    } seq_state_t;

endpackage

// File: rtl/irq_qualify.sv
// Request qualifier: decides whether a priority code beats the current mask.
// Assumes code 0 is never a valid interrupt and lower codes are more urgent.
module irq_qualify #(
    parameter int CW = 4
) (
    input  logic          req_i,
    input  logic [CW-1:0] code_i,
    input  logic [CW-1:0] mask_i,
    output logic          hit_o
);

    // purpose: nonzero code at or below the mask value qualifies
    always_comb begin
        hit_o = req_i && (code_i != '0) && (code_i <= mask_i);
    end

endmodule

// File: rtl/ctx_addr_gen.sv
// Memory port driver for the context switch: address, direction and data per state.
// Assumes the vector table starts at address 0 with two words per code.
module ctx_addr_gen
    import irq_ctx_pkg::*;
#(
    parameter int DW     = 16,
    parameter int CW     = 4,
    parameter int REG_WP = 13,
    parameter int REG_PC = 14,
    parameter int REG_ST = 15
) (
    input  seq_state_t    state_i,
    input  logic [CW-1:0] code_i,
    input  logic [DW-1:0] nwp_i,
    input  logic [DW-1:0] wp_i,
    input  logic [DW-1:0] pc_i,
    input  logic [DW-1:0] st_i,
    output logic          req_o,
    output logic          we_o,
    output logic [DW-1:0] addr_o,
    output logic [DW-1:0] wdata_o,
    output logic          ack_o
);

    localparam int PADW = DW - CW - 2;
    localparam logic [DW-1:0] OFF_WP = DW'(2 * REG_WP);
    localparam logic [DW-1:0] OFF_PC = DW'(2 * REG_PC);
    localparam logic [DW-1:0] OFF_ST = DW'(2 * REG_ST);

    logic [DW-1:0] vec_base;

    // purpose: vector entry address is code times four
    always_comb begin
        vec_base = {{PADW{1'b0}}, code_i, 2'b00};
    end

    // purpose: select the access for the current sequencer state
    always_comb begin
        req_o   = 1'b1;
        we_o    = 1'b0;
        addr_o  = '0;
        wdata_o = '0;
        ack_o   = 1'b0;
        unique case (state_i)
            SQ_VWP: begin
                addr_o = vec_base;
                ack_o  = 1'b1;
            end
            SQ_VPC: addr_o = vec_base + DW'(2);
            SQ_SWP: begin
                we_o    = 1'b1;
                addr_o  = nwp_i + OFF_WP;
                wdata_o = wp_i;
            end
            SQ_SPC: begin
                we_o    = 1'b1;
                addr_o  = nwp_i + OFF_PC;
                wdata_o = pc_i;
            end
            SQ_SST: begin
                we_o    = 1'b1;
                addr_o  = nwp_i + OFF_ST;
                wdata_o = st_i;
            end
            default: req_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/ctx_regs.sv
// Context registers (workspace pointer, program counter, status) with a
// deferred mask update. Assumes arm and commit never fall on the same edge.
module ctx_regs #(
    parameter int DW = 16,
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ld_i,
    input  logic [DW-1:0] ld_wp_i,
    input  logic [DW-1:0] ld_pc_i,
    input  logic [DW-1:0] ld_st_i,
    input  logic          arm_i,
    input  logic [CW-1:0] arm_code_i,
    input  logic          commit_i,
    input  logic [DW-1:0] nwp_i,
    input  logic [DW-1:0] npc_i,
    output logic [DW-1:0] wp_o,
    output logic [DW-1:0] pc_o,
    output logic [DW-1:0] st_o
);

    logic          pend_q;
    logic [CW-1:0] pend_code_q;
    logic [CW-1:0] new_mask;

    // purpose: four-bit decrement of the accepted level
    always_comb begin
        new_mask = pend_code_q - CW'(1);
    end

    // purpose: remember the accepted level until the status has been saved
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q      <= 1'b0;
            pend_code_q <= '0;
        end else if (arm_i) begin
            pend_q      <= 1'b1;
            pend_code_q <= arm_code_i;
        end else if (commit_i) begin
            pend_q      <= 1'b0;
        end
    end

    // purpose: load from the core or switch to the new context
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp_o <= '0;
            pc_o <= '0;
            st_o <= '0;
        end else if (commit_i) begin
            wp_o <= nwp_i;
            pc_o <= npc_i;
            if (pend_q) begin
                st_o[CW-1:0] <= new_mask;
            end
        end else if (ld_i) begin
            wp_o <= ld_wp_i;
            pc_o <= ld_pc_i;
            st_o <= ld_st_i;
        end
    end

endmodule

// File: rtl/irq_ctx_seq.sv
// Interrupt entry sequencer top: qualifies requests at boundaries or in idle,
// walks vector fetch and context save, and commits the new context.
// Assumes the memory port returns mem_ready only while mem_req is high.
module irq_ctx_seq
    import irq_ctx_pkg::*;
#(
    parameter int DW = 16,
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          irq_req,
    input  logic [CW-1:0] irq_code,
    input  logic          at_boundary,
    input  logic          idle_cmd,
    input  logic          ld_en,
    input  logic [DW-1:0] ld_wp,
    input  logic [DW-1:0] ld_pc,
    input  logic [DW-1:0] ld_st,
    output logic          mem_req,
    output logic          mem_we,
    output logic [DW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata,
    input  logic          mem_ready,
    output logic          irq_ack,
    output logic          busy,
    output logic          done,
    output logic          idle_o,
    output logic [DW-1:0] wp_o,
    output logic [DW-1:0] pc_o,
    output logic [DW-1:0] st_o
);

    seq_state_t    state_q;
    logic [CW-1:0] code_q;
    logic [DW-1:0] nwp_q;
    logic [DW-1:0] npc_q;
    logic          done_q;
    logic          hit;
    logic          accept;
    logic          commit;
    logic          ld_ok;

    irq_qualify #(.CW(CW)) qual_i (
        .req_i  (irq_req),
        .code_i (irq_code),
        .mask_i (st_o[CW-1:0]),
        .hit_o  (hit)
    );

    // purpose: acceptance, completion and load gating
    always_comb begin
        accept = ((state_q == SQ_RUN) && at_boundary && hit) ||
                 ((state_q == SQ_IDLE) && hit);
        commit = (state_q == SQ_SST) && mem_ready;
        ld_ok  = ld_en && (state_q == SQ_RUN) && !accept;
    end

    // purpose: sequencer state, latched code and fetched vector words
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SQ_RUN;
            code_q  <= '0;
            nwp_q   <= '0;
            npc_q   <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (state_q)
                SQ_RUN, SQ_IDLE: begin
                    if (accept) begin
                        state_q <= SQ_VWP;
                        code_q  <= irq_code;
                    end else if (state_q == SQ_RUN && idle_cmd) begin
                        state_q <= SQ_IDLE;
                    end
                end
                SQ_VWP: if (mem_ready) begin
                    nwp_q   <= {mem_rdata[DW-1:1], 1'b0};
                    state_q <= SQ_VPC;
                end
                SQ_VPC: if (mem_ready) begin
                    npc_q   <= mem_rdata;
                    state_q <= SQ_SWP;
                end
                SQ_SWP: if (mem_ready) state_q <= SQ_SPC;
                SQ_SPC: if (mem_ready) state_q <= SQ_SST;
                SQ_SST: if (mem_ready) begin
                    state_q <= SQ_RUN;
                    done_q  <= 1'b1;
                end
                default: state_q <= SQ_RUN;
            endcase
        end
    end

    ctx_regs #(.DW(DW), .CW(CW)) regs_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .ld_i       (ld_ok),
        .ld_wp_i    (ld_wp),
        .ld_pc_i    (ld_pc),
        .ld_st_i    (ld_st),
        .arm_i      (accept),
        .arm_code_i (irq_code),
        .commit_i   (commit),
        .nwp_i      (nwp_q),
        .npc_i      (npc_q),
        .wp_o       (wp_o),
        .pc_o       (pc_o),
        .st_o       (st_o)
    );

    ctx_addr_gen #(.DW(DW), .CW(CW)) agen_i (
        .state_i (state_q),
        .code_i  (code_q),
        .nwp_i   (nwp_q),
        .wp_i    (wp_o),
        .pc_i    (pc_o),
        .st_i    (st_o),
        .req_o   (mem_req),
        .we_o    (mem_we),
        .addr_o  (mem_addr),
        .wdata_o (mem_wdata),
        .ack_o   (irq_ack)
    );

    // purpose: status outputs derived from the state
    always_comb begin
        busy   = (state_q != SQ_RUN) && (state_q != SQ_IDLE);
        idle_o = (state_q == SQ_IDLE);
        done   = done_q;
    end

endmodule

// File: rtl/irq_ctx_seq_chk.sv
// Property checker for the interrupt entry sequencer, bound to the top.
// Assumes request code is steady on the accepting edge.
module irq_ctx_seq_chk #(
    parameter int DW = 16,
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          irq_req,
    input  logic [CW-1:0] irq_code,
    input  logic          mem_req,
    input  logic          mem_we,
    input  logic [DW-1:0] mem_addr,
    input  logic          mem_ready,
    input  logic          irq_ack,
    input  logic          busy,
    input  logic          done,
    input  logic          idle_o,
    input  logic [DW-1:0] st_o
);

    logic [CW-1:0] cap_code;

    // purpose: track the code presented while no switch is running
    always_ff @(posedge clk) begin
        if (!rst_n) cap_code <= '0;
        else if (!busy) cap_code <= irq_code;
    end

    AST_ACCEPT_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> ($past(irq_req) && ($past(irq_code) != '0) &&
                         ($past(irq_code) <= $past(st_o[CW-1:0])))); // R2
    AST_ACK_VECTOR_READ: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ack |-> (busy && mem_req && !mem_we && (mem_addr[CW+1:2] == cap_code))); // R4
    AST_WRITE_IN_SWITCH: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (busy && mem_req && !irq_ack)); // R5
    AST_STATUS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> $stable(st_o)); // R6
    AST_MASK_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (st_o[CW-1:0] == cap_code - CW'(1))); // R6
    AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy))); // R7
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R7
    AST_HOLD_UNTIL_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we))); // R8
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        idle_o |-> (!busy && !mem_req)); // R9

endmodule

bind irq_ctx_seq irq_ctx_seq_chk #(.DW(DW), .CW(CW)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq_req   (irq_req),
    .irq_code  (irq_code),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_ready (mem_ready),
    .irq_ack   (irq_ack),
    .busy      (busy),
    .done      (done),
    .idle_o    (idle_o),
    .st_o      (st_o)
);

// File: tb/irq_ctx_seq_tb_top.sv
module irq_ctx_seq_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        irq_req = 1'b0;
    logic [3:0]  irq_code = 4'd0;
    logic        at_boundary = 1'b0;
    logic        idle_cmd = 1'b0;
    logic        ld_en = 1'b0;
    logic [15:0] ld_wp = '0, ld_pc = '0, ld_st = '0;
    logic        mem_req, mem_we;
    logic [15:0] mem_addr, mem_wdata;
    logic [15:0] mem_rdata = '0;
    logic        mem_ready = 1'b0;
    logic        irq_ack, busy, done, idle_o;
    logic [15:0] wp_o, pc_o, st_o;

    always #5 clk = ~clk;

    irq_ctx_seq dut_i (
        .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .irq_code(irq_code),
        .at_boundary(at_boundary), .idle_cmd(idle_cmd), .ld_en(ld_en),
        .ld_wp(ld_wp), .ld_pc(ld_pc), .ld_st(ld_st), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_ready(mem_ready), .irq_ack(irq_ack),
        .busy(busy), .done(done), .idle_o(idle_o), .wp_o(wp_o), .pc_o(pc_o),
        .st_o(st_o)
    );

    // fields: req, bnd, code, mask, lat, acc
    localparam int NV = 11;
    localparam logic [12:0] VTAB [0:NV-1] = '{
        {1'b1, 1'b1, 4'd1,  4'd15, 2'd0, 1'b1},
        {1'b1, 1'b1, 4'd5,  4'd7,  2'd2, 1'b1},
        {1'b1, 1'b1, 4'd7,  4'd7,  2'd1, 1'b1},
        {1'b1, 1'b1, 4'd8,  4'd7,  2'd0, 1'b0},
        {1'b1, 1'b1, 4'd0,  4'd15, 2'd0, 1'b0},
        {1'b1, 1'b0, 4'd3,  4'd15, 2'd0, 1'b0},
        {1'b1, 1'b1, 4'd15, 4'd15, 2'd3, 1'b1},
        {1'b1, 1'b1, 4'd1,  4'd1,  2'd0, 1'b1},
        {1'b1, 1'b1, 4'd2,  4'd0,  2'd0, 1'b0},
        {1'b1, 1'b1, 4'd9,  4'd12, 2'd1, 1'b1},
        {1'b0, 1'b1, 4'd2,  4'd15, 2'd0, 1'b0}
    };

    int n_chk = 0, n_fail = 0;
    logic [15:0] mem [0:511];
    int lat = 0, wait_cnt = 0, log_n = 0;
    logic [15:0] log_addr [0:7];
    logic [15:0] log_data [0:7];
    logic        log_we [0:7];
    logic        log_ack [0:7];
    logic [3:0]  mon_mask = 4'd0;
    int          mon_bad = 0;
    logic        busy_seen = 1'b0;

    task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] vwp(input logic [3:0] c);
        return 16'h0100 + {7'd0, c, 5'd0};
    endfunction
    function automatic logic [15:0] vpc(input logic [3:0] c);
        return 16'h4000 + {11'd0, c, 1'b0};
    endfunction

    // memory model: grants after lat wait cycles, all on the falling edge
    always @(negedge clk) begin
        if (mem_ready) begin
            mem_ready = 1'b0;
            wait_cnt = 0;
        end else if (mem_req) begin
            if (wait_cnt >= lat) begin
                if (log_n < 8) begin
                    log_addr[log_n] = mem_addr;
                    log_we[log_n]   = mem_we;
                    log_ack[log_n]  = irq_ack;
                    log_data[log_n] = mem_we ? mem_wdata : mem[mem_addr[9:1]];
                end
                log_n++;
                if (mem_we) mem[mem_addr[9:1]] = mem_wdata;
                else mem_rdata = mem[mem_addr[9:1]];
                mem_ready = 1'b1;
            end else begin
                wait_cnt++;
            end
        end
        if (busy) busy_seen = 1'b1;
        if (busy && st_o[3:0] != mon_mask) mon_bad++;
    end

    task automatic load_ctx(input logic [15:0] w, input logic [15:0] p, input logic [15:0] s);
        @(negedge clk);
        ld_en = 1'b1; ld_wp = w; ld_pc = p; ld_st = s;
        @(negedge clk);
        ld_en = 1'b0;
    endtask

    task automatic wait_done();
        for (int k = 0; k < 80 && !done; k++) @(negedge clk);
    endtask

    task automatic check_switch(input logic [3:0] c, input logic [3:0] m, input string tag);
        chk(done === 1'b1, {tag, " R7 done"}, done, 1);
        chk(busy === 1'b0, "R7 busy low at done", busy, 0);
        chk(wp_o === vwp(c), "R4 new wp", wp_o, vwp(c));
        chk(pc_o === vpc(c), "R4 new pc", pc_o, vpc(c));
        chk(st_o === {12'hC00, c - 4'd1}, "R6 new mask", st_o, {12'hC00, c - 4'd1});
        chk(log_n == 5, "R5 access count", log_n, 5);
        chk(log_addr[0] === {10'd0, c, 2'b00} && !log_we[0] && log_ack[0], "R4 vector wp read", log_addr[0], {10'd0, c, 2'b00});
        chk(log_addr[1] === {10'd0, c, 2'b10} && !log_we[1] && !log_ack[1], "R4 vector pc read", log_addr[1], {10'd0, c, 2'b10});
        chk(log_addr[2] === vwp(c) + 16'd26 && log_we[2] && log_data[2] === 16'h0080 && !log_ack[2], "R5 save wp", log_data[2], 16'h0080);
        chk(log_addr[3] === vwp(c) + 16'd28 && log_we[3] && log_data[3] === 16'h1234, "R5 save pc", log_data[3], 16'h1234);
        chk(log_addr[4] === vwp(c) + 16'd30 && log_we[4] && log_data[4] === {12'hC00, m}, "R6 saved old status", log_data[4], {12'hC00, m});
        chk(mon_bad == 0, "R6 mask held while busy", mon_bad, 0);
        @(negedge clk);
        chk(done === 1'b0, "R7 done single pulse", done, 0);
    endtask

    initial begin
        for (int i = 0; i < 512; i++) mem[i] = 16'h0000;
        for (int c = 0; c < 16; c++) begin
            mem[c * 2]     = vwp(4'(c)) | 16'h0001;  // bit 0 set: must be cleared
            mem[c * 2 + 1] = vpc(4'(c));
        end
        repeat (3) @(negedge clk);
        chk(wp_o === 16'd0 && pc_o === 16'd0 && st_o === 16'd0, "R1 regs in reset", st_o, 0);
        chk(!busy && !done && !irq_ack && !idle_o && !mem_req && !mem_we, "R1 outputs in reset", {busy, done, irq_ack, mem_req}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(wp_o === 16'd0 && !busy && !mem_req, "R1 after release", wp_o, 0);

        // table walk: R2, R3, R4, R5, R6, R7, R8
        for (int v = 0; v < NV; v++) begin
            logic [12:0] e;
            e = VTAB[v];
            lat = int'(e[2:1]);
            load_ctx(16'h0080, 16'h1234, {12'hC00, e[6:3]});
            mon_mask = e[6:3];
            log_n = 0; busy_seen = 1'b0; mon_bad = 0;
            irq_req = e[12]; at_boundary = e[11]; irq_code = e[10:7];
            @(negedge clk);
            at_boundary = 1'b0;
            chk(busy === e[0], e[0] ? "R2 accepted" : "R3 ignored", busy, e[0]);
            if (e[0]) begin
                wait_done();
                check_switch(e[10:7], e[6:3], "R8");
            end else begin
                repeat (5) @(negedge clk);
                chk(!busy_seen && log_n == 0, "R3 no access", log_n, 0);
                chk(wp_o === 16'h0080 && st_o === {12'hC00, e[6:3]}, "R3 context kept", st_o, {12'hC00, e[6:3]});
            end
            irq_req = 1'b0; irq_code = 4'd0;
        end

        // idle: R9
        lat = 0;
        load_ctx(16'h0080, 16'h1234, 16'hC003);
        mon_mask = 4'd3; log_n = 0; mon_bad = 0;
        idle_cmd = 1'b1;
        @(negedge clk);
        idle_cmd = 1'b0;
        chk(idle_o === 1'b1 && !busy, "R9 idle entered", idle_o, 1);
        irq_req = 1'b1; irq_code = 4'd5;
        repeat (4) @(negedge clk);
        chk(idle_o === 1'b1 && !busy && log_n == 0, "R9 weak request ignored", idle_o, 1);
        irq_code = 4'd2;
        @(negedge clk);
        chk(busy === 1'b1 && idle_o === 1'b0, "R9 wake without boundary", busy, 1);
        wait_done();
        check_switch(4'd2, 4'd3, "R9");
        irq_req = 1'b0;

        // load while busy ignored: R10
        lat = 3;
        load_ctx(16'h0080, 16'h1234, 16'hC00F);
        chk(wp_o === 16'h0080 && st_o === 16'hC00F, "R10 load in run", st_o, 16'hC00F);
        mon_mask = 4'd15; log_n = 0; mon_bad = 0;
        irq_req = 1'b1; irq_code = 4'd4; at_boundary = 1'b1;
        @(negedge clk);
        at_boundary = 1'b0;
        ld_en = 1'b1; ld_wp = 16'hBEEF; ld_pc = 16'hDEAD; ld_st = 16'h0000;
        @(negedge clk);
        ld_en = 1'b0;
        wait_done();
        check_switch(4'd4, 4'd15, "R10");
        irq_req = 1'b0;

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog R7 actual=%h expected=%h", 0, 1);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule